// File: doc/BRIEF.md
# Programmable Shift-Register Clock Divider

This block divides an input clock by a programmable ratio of N+2. A chain of flip-flops whose serial input is held at one fills up, one stage per rising clock edge. A tap selected by N is sampled on the falling edge by a capture flop. That capture flop is the divided output, and it also clears the chain. One full period therefore lasts N+1 fill edges plus one clear edge.

N is taken from the length input while reset is held, and it is clamped into the supported range 1 to 64. Later changes on the length input have no effect until the next reset. The output is high for exactly one input clock period in every output period.

Top module: `fdiv_shiftreg`

## Requirements
- R1: While `rst_n` is low at a clock edge, `div_out` goes or stays low and every chain stage is cleared. The first fill edge is the first rising edge at which `rst_n` is sampled high.
- R2: The ratio setting is captured from `len_sel` only while `rst_n` is low. Changes to `len_sel` after release do not change the output timing.
- R3: A `len_sel` value below 1 (that is, 0) is treated as N = 1.
- R4: A `len_sel` value above 64 is treated as N = 64.
- R5: While the clear is inactive, each rising edge shifts a one into stage 0 and moves every stage up by one. The chain always holds a contiguous run of ones starting at stage 0.
- R6: After reset release, `div_out` first goes high at the falling edge that follows rising edge N+1.
- R7: A rising edge that sees the capture output high empties every chain stage instead of shifting.
- R8: Consecutive rising transitions of `div_out` are N+2 input clock periods apart.
- R9: `div_out` is high for exactly one input clock period in each output period, and is never high on two consecutive rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset; also loads the ratio setting |
| len_sel | input | LEN_W (7) | Programmed N, clamped to 1..64 |
| div_out | output | 1 | Divided clock, high one input period per N+2 |

## Verification
The clear and the fill act on the same rising edge. When the capture output is high, that edge must empty the chain rather than shift in another one. This is provoked on every period of every N, and it is judged by the spacing of the output pulses, which becomes N+2 only if the blocked shift is counted correctly. Reset can also coincide with a high output. The bench asserts reset in the very period where `div_out` is high. It then checks that the output drops and that the next fill starts from the first released edge.

// File: rtl/fdiv_pkg.sv
// Package: shared limits and the ratio clamp used by the divider.
// Assumes callers pass values that fit in 32 bits.
package fdiv_pkg;
    localparam int DEF_LEN_W = 7;
    localparam int DEF_N_MIN = 1;
    localparam int DEF_N_MAX = 64;

    // Bound a requested length into [lo, hi].
    function automatic int clamp_len(input int val, input int lo, input int hi);
        if (val < lo) return lo;
        if (val > hi) return hi;
        return val;
    endfunction
endpackage

// File: rtl/fdiv_len_latch.sv
// Holds the clamped ratio setting. The value is loaded on every edge while
// reset is held and is frozen after release.
// Assumes N_MIN >= 1 and N_MAX < 2**LEN_W.
module fdiv_len_latch
    import fdiv_pkg::*;
#(
    parameter int LEN_W = DEF_LEN_W,
    parameter int N_MIN = DEF_N_MIN,
    parameter int N_MAX = DEF_N_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] len_sel,
    output logic [LEN_W-1:0] n_q
);
    logic [LEN_W-1:0] n_bound;

    // Clamp the raw request into the supported range.
    always_comb begin
        n_bound = LEN_W'(clamp_len(int'(len_sel), N_MIN, N_MAX));
    end

    // Load the setting during reset; hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q <= n_bound;
        end
    end

    assert_len_in_range_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        (int'(n_q) >= N_MIN) && (int'(n_q) <= N_MAX));
    assert_len_frozen_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(n_q));
endmodule

// File: rtl/fdiv_fill_chain.sv
// Ones-filling shift chain with a selectable tap. Stage 0 takes a constant
// one. A high clear empties every stage on the rising edge.
// Assumes the tap index stays within 0..N_MAX.
module fdiv_fill_chain
    import fdiv_pkg::*;
#(
    parameter int LEN_W = DEF_LEN_W,
    parameter int N_MAX = DEF_N_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [LEN_W-1:0] tap_sel,
    output logic             tap
);
    localparam int DEPTH = N_MAX + 1;

    logic [DEPTH-1:0] stage;

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_stage
            logic d_in;
            if (gi == 0) begin : g_head
                // Serial input is tied high.
                assign d_in = 1'b1;
            end else begin : g_body
                // Each stage takes its lower neighbour.
                assign d_in = stage[gi-1];
            end

            // Shift on the rising edge unless reset or clear holds it at zero.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    stage[gi] <= 1'b0;
                end else begin
                    stage[gi] <= d_in;
                end
            end

            if (gi > 0) begin : g_thermo
                assert_fill_contiguous_R5 : assert property (@(posedge clk) disable iff (!rst_n)
                    stage[gi] |-> stage[gi-1]);
            end
        end
    endgenerate

    // Pick the programmed stage as the chain output.
    always_comb begin
        tap = stage[tap_sel];
    end

    assert_clear_empties_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (stage == '0));
    assert_head_fills_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> stage[0]);
endmodule

// File: rtl/fdiv_capture.sv
// Falling-edge capture flop that samples the chain tap. Its output is both
// the divided clock and the chain clear.
// Assumes rst_n is stable around the falling edge.
module fdiv_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic tap,
    output logic q
);
    // Sample the tap on the falling edge; clear it under reset.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= tap;
        end
    end

    assert_capture_follows_tap_R6 : assert property (@(negedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (q == $past(tap)));
endmodule

// File: rtl/fdiv_shiftreg.sv
// Top of the N+2 clock divider: ratio latch, fill chain, capture flop.
// Assumes len_sel is held steady while rst_n is low.
module fdiv_shiftreg
    import fdiv_pkg::*;
#(
    parameter int LEN_W = DEF_LEN_W,
    parameter int N_MIN = DEF_N_MIN,
    parameter int N_MAX = DEF_N_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] len_sel,
    output logic             div_out
);
    localparam int GAP_W = LEN_W + 2;

    logic [LEN_W-1:0] n_q;
    logic             tap;
    logic             cap_q;

    fdiv_len_latch #(.LEN_W(LEN_W), .N_MIN(N_MIN), .N_MAX(N_MAX)) u_len (
        .clk(clk), .rst_n(rst_n), .len_sel(len_sel), .n_q(n_q)
    );

    fdiv_fill_chain #(.LEN_W(LEN_W), .N_MAX(N_MAX)) u_chain (
        .clk(clk), .rst_n(rst_n), .clr(cap_q), .tap_sel(n_q), .tap(tap)
    );

    fdiv_capture u_cap (
        .clk(clk), .rst_n(rst_n), .tap(tap), .q(cap_q)
    );

    // Drive the divided clock from the capture flop.
    always_comb begin
        div_out = cap_q;
    end

    // Checker state: rising edges since the last high sample.
    logic [GAP_W-1:0] gap;
    logic             seen;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (div_out) begin
            gap  <= GAP_W'(1);
            seen <= 1'b1;
        end else begin
            gap  <= gap + GAP_W'(1);
        end
    end

    assert_single_high_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        div_out |=> !div_out);
    assert_period_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        (div_out && seen) |-> (gap == GAP_W'(n_q) + GAP_W'(2)));
    assert_first_pulse_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (div_out && !seen) |-> (gap == GAP_W'(n_q) + GAP_W'(1)));
endmodule

// File: tb/test_fdiv_shiftreg.sv
module test_fdiv_shiftreg;
    localparam int LEN_W = 7;
    localparam int NV    = 8;
    localparam int VEC_N [NV] = '{0, 1, 2, 5, 17, 64, 100, 127};
    localparam int VEC_P [NV] = '{3, 3, 4, 7, 19, 66, 66, 66};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LEN_W-1:0] len_sel = '0;
    logic             div_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    fdiv_shiftreg i_fdiv_shiftreg (
        .clk(clk), .rst_n(rst_n), .len_sel(len_sel), .div_out(div_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Hold reset with the given setting, then release after a rising edge.
    task automatic do_reset(input int n);
        @(posedge clk); #1;
        rst_n   = 1'b0;
        len_sel = LEN_W'(n);
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    // Sample after each rising edge; report first high index, spacing, width.
    task automatic measure(input int p, input bit disturb, output int first,
                           output int second, output int highs, output int dbl);
        bit prev = 1'b0;
        first = -1; second = -1; highs = 0; dbl = 0;
        for (int k = 1; k <= 3 * p; k++) begin
            @(posedge clk); #1;
            if (disturb && k == 1) len_sel = LEN_W'(3);
            if (div_out) begin
                highs++;
                if (prev) dbl++;
                if (first < 0) first = k;
                else if (second < 0) second = k;
            end
            prev = div_out;
        end
    endtask

    initial begin
        int first, second, highs, dbl;
        // Vector table walk.
        for (int v = 0; v < NV; v++) begin
            do_reset(VEC_N[v]);
            measure(VEC_P[v], v[0], first, second, highs, dbl);
            // R6 first pulse; R3/R4 clamping appears in the expected value.
            check(first == VEC_P[v], (VEC_N[v] == 0) ? "R3" : (VEC_N[v] > 64) ? "R4" : "R6",
                  first, VEC_P[v]);
            // R8 spacing; R2 when len_sel was disturbed after release.
            check(second - first == VEC_P[v], v[0] ? "R2" : "R8", second - first, VEC_P[v]);
            // R9 width: three one-cycle pulses in three periods.
            check(highs == 3 && dbl == 0, "R9", highs, 3);
        end

        // R1: output low and held during reset with the clock running.
        @(posedge clk); #1;
        rst_n = 1'b0; len_sel = LEN_W'(3);
        repeat (4) begin
            @(posedge clk); #1;
            check(div_out == 1'b0, "R1", int'(div_out), 0);
        end
        #1 rst_n = 1'b1;
        // R5/R7: with N=3, pulses at samples 5 and 10.
        measure(5, 1'b0, first, second, highs, dbl);
        check(first == 5, "R5", first, 5);
        check(second == 10, "R7", second, 10);

        // R1: reset landing on a high output drops it and restarts the fill.
        do_reset(3);
        for (int k = 1; k <= 5; k++) begin
            @(posedge clk); #1;
        end
        check(div_out == 1'b1, "R6", int'(div_out), 1);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check(div_out == 1'b0, "R1", int'(div_out), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        measure(5, 1'b0, first, second, highs, dbl);
        check(first == 5, "R1", first, 5);

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        while (!done && cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule